// File: doc/BRIEF.md
# Dual-Width Serial Pulse Modulator

This block turns a data word into a train of pulses, one bit period per data bit. Each bit period lasts a programmable number of clock cycles set by a baud divisor. At the start of every bit period the pulse output rises. The current output bit of an internal shift register then picks one of two programmed compare values. The pulse ends when the pulse counter reaches that value. A zero bit therefore gives one pulse width and a one bit gives the other.

Software writes the two compare values, the divisor and the data word through a small register write port, then pulses a start strobe. At that strobe the block takes a private copy of every setting. Writes made while a transfer runs only count from the next start. The baud timer ends each bit period. It restarts the pulse counter and advances the shift register, and the data goes out most significant bit first. A single-action input, sampled at start, limits each bit period to one compare event. Without it, the output keeps toggling on each compare match inside a long period. A done flag rises after the eighth bit.

Top module: `dual_width_pwm`

## Requirements
- R1: After reset `pulse_o` and `done_o` are low, and they stay low until a start strobe is accepted.
- R2: The first bit period begins in the cycle after the accepted start edge. Each period lasts divisor+1 cycles, and the data word is sent most significant bit first over 8 periods.
- R3: Write address 0 sets compare A, address 1 sets compare B, address 2 sets the baud divisor, and address 3 sets the data word. A data bit of 0 selects compare A for its period and a data bit of 1 selects compare B.
- R4: With `single_act_i` high at start, the output is high for cycles t < C of each period and low for the rest. Here C is the selected compare value and t is the cycle index inside the period, starting at 0.
- R5: With `single_act_i` low at start and a nonzero C, the output in cycle t of a period is high exactly when floor(t/C) is even. It starts high at each period start and toggles on each compare match.
- R6: A selected compare value of 0 keeps the output low for the whole bit period in either mode.
- R7: A selected compare value at or above divisor+1 keeps the output high for the whole bit period in either mode.
- R8: `done_o` is low during a transfer. It rises in the cycle after the last period ends, and `pulse_o` is low at that point. Both hold until the next accepted start.
- R9: Register writes and start strobes made during a transfer do not change that transfer's waveform. The next accepted start uses the register values present before its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select: 0 compare A, 1 compare B, 2 divisor, 3 data |
| wr_data | input | CNT_W | Write value; the data word uses its low DATA_W bits |
| single_act_i | input | 1 | One compare event per bit period, sampled at start |
| start_i | input | 1 | Start strobe, ignored while a transfer runs |
| pulse_o | output | 1 | Modulated pulse output |
| done_o | output | 1 | Transfer finished flag |

## Verification
The hardest situation to reach is a register rewrite plus a second start strobe arriving in the middle of a running transfer. The old shadow copies must keep governing every remaining period, and the new values must take over only at the following start. The bench reaches it with a disturbance pass. Partway through the third bit period it rewrites compare A, the divisor and the data word, then strobes start while still checking the running waveform against the old settings. It then launches a fresh transfer and checks that one against the new settings. The remaining stimulus sweeps divisors, compare pairs that include 0 and values at and beyond the period, both modes, and several data patterns. In every swept case the expected level of each cycle is computed arithmetically.

// File: rtl/dual_width_pwm.sv
module dual_width_pwm #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             single_act_i,
  input  logic             start_i,
  output logic             pulse_o,
  output logic             done_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
  localparam logic [CNT_W:0] ONE_X = (CNT_W+1)'(1);

  logic [CNT_W-1:0]  cmp_a_r, cmp_b_r, div_r;
  logic [DATA_W-1:0] data_r;

  logic [CNT_W-1:0]  cmp_a_s, cmp_b_s, div_s;
  logic              once_s;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  tcnt, pcnt;
  logic              lvl, fired, busy, done;

  wire [DATA_W-1:0] shreg_nx  = shreg << 1;
  wire [CNT_W-1:0]  cur_cmp   = shreg[DATA_W-1]    ? cmp_b_s : cmp_a_s;
  wire [CNT_W-1:0]  nxt_cmp   = shreg_nx[DATA_W-1] ? cmp_b_s : cmp_a_s;
  wire [CNT_W-1:0]  first_cmp = data_r[DATA_W-1]   ? cmp_b_r : cmp_a_r;
  wire period_end = (tcnt == div_s);
  wire last_bit   = (idx == LAST_IDX);
  wire hit        = ({1'b0, pcnt} + ONE_X) == {1'b0, cur_cmp};
  wire act        = hit && !(once_s && fired);

  assign pulse_o = lvl;
  assign done_o  = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_r <= '0;
      cmp_b_r <= '0;
      div_r   <= '0;
      data_r  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: cmp_a_r <= wr_data;
        2'd1: cmp_b_r <= wr_data;
        2'd2: div_r   <= wr_data;
        default: data_r <= wr_data[DATA_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_s <= '0;
      cmp_b_s <= '0;
      div_s   <= '0;
      once_s  <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      tcnt    <= '0;
      pcnt    <= '0;
      lvl     <= 1'b0;
      fired   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (!busy) begin
      if (start_i) begin
        cmp_a_s <= cmp_a_r;
        cmp_b_s <= cmp_b_r;
        div_s   <= div_r;
        once_s  <= single_act_i;
        shreg   <= data_r;
        idx     <= '0;
        tcnt    <= '0;
        pcnt    <= '0;
        lvl     <= (first_cmp != '0);
        fired   <= 1'b0;
        busy    <= 1'b1;
        done    <= 1'b0;
      end
    end else if (period_end) begin
      tcnt  <= '0;
      pcnt  <= '0;
      fired <= 1'b0;
      if (last_bit) begin
        busy <= 1'b0;
        done <= 1'b1;
        lvl  <= 1'b0;
      end else begin
        shreg <= shreg_nx;
        idx   <= idx + 1'b1;
        lvl   <= (nxt_cmp != '0);
      end
    end else begin
      tcnt <= tcnt + 1'b1;
      pcnt <= hit ? '0 : pcnt + 1'b1;
      if (hit) fired <= 1'b1;
      if (act) lvl <= ~lvl;
    end
  end

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulse_o);

  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy));

  // R6
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_cmp == '0) |-> !pulse_o);

  // R2
  tcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt <= div_s));

  // R4
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && once_s && !pulse_o && !period_end) |=> !pulse_o);

  // R9
  shadow_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(div_s) && $stable(cmp_a_s) && $stable(cmp_b_s) && $stable(once_s)));
endmodule

// File: tb/dual_width_pwm_tb.sv
module dual_width_pwm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic single_act_i = 1'b0;
  logic start_i = 1'b0;
  logic pulse_o, done_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_width_pwm #(.CNT_W(8), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .single_act_i(single_act_i), .start_i(start_i),
    .pulse_o(pulse_o), .done_o(done_o));

  function automatic bit exp_level(int c, int t, bit os);
    if (c == 0) return 1'b0;
    if (os) return t < c;
    return ((t / c) % 2) == 0;
  endfunction

  task automatic chk(bit act, bit exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(int a, int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Starts and checks a transfer; optional disturbance in the third period (R9).
  task automatic run(int ca, int cb, int dv, int dat, bit os, bit disturb);
    int p = dv + 1;
    @(negedge clk);
    single_act_i = os; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; single_act_i = ~os;
    chk(done_o, 1'b0, "R8 done low in transfer");
    for (int k = 0; k < 8; k++) begin
      for (int t = 0; t < p; t++) begin
        int c = ((dat >> (7 - k)) & 1) ? cb : ca;
        string tag;
        if (c == 0) tag = "R6/R3 zero compare";
        else if (c >= p) tag = "R7/R3 full period";
        else if (os) tag = "R4/R2 single action";
        else tag = "R5/R2 repeat toggle";
        if (disturb && k == 2) tag = "R9 mid-transfer rewrite";
        chk(pulse_o, exp_level(c, t, os), tag);
        wr_en = 1'b0; start_i = 1'b0;
        if (disturb && k == 2) begin
          if (t == 0) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd4; end
          if (t == 1) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd1; end
          if (t == 2) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00; end
          if (t == 3) start_i = 1'b1;
        end
        @(negedge clk);
      end
    end
    wr_en = 1'b0; start_i = 1'b0;
    chk(done_o, 1'b1, "R8 done after last bit");
    chk(pulse_o, 1'b0, "R8 pulse low when done");
    @(negedge clk);
    chk(done_o, 1'b1, "R8 done held");
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        bad++;
        total++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int cmps[6];
    int divs[5] = '{0, 1, 2, 4, 6};
    int dats[2] = '{8'hA5, 8'h3C};
    repeat (3) @(negedge clk);
    chk(pulse_o, 1'b0, "R1 reset pulse");
    chk(done_o, 1'b0, "R1 reset done");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pulse_o, 1'b0, "R1 idle pulse");
    chk(done_o, 1'b0, "R1 idle done");

    foreach (divs[di]) begin
      int dv = divs[di];
      cmps = '{0, 1, 2, 3, dv + 1, dv + 3};
      wr(2, dv);
      foreach (cmps[ai]) foreach (cmps[bi]) for (int m = 0; m < 2; m++) begin
        wr(0, cmps[ai]);
        wr(1, cmps[bi]);
        wr(3, dats[(ai + bi + m) % 2]);
        run(cmps[ai], cmps[bi], dv, dats[(ai + bi + m) % 2], m[0], 1'b0);
      end
    end

    // R2/R3 MSB-first ordering with sparse patterns
    wr(0, 0); wr(1, 9); wr(2, 3);
    wr(3, 8'h01); run(0, 9, 3, 8'h01, 1'b1, 1'b0);
    wr(3, 8'hFE); run(0, 9, 3, 8'hFE, 1'b0, 1'b0);

    // R9 rewrite and start strobe during a transfer, then new values apply
    wr(0, 1); wr(1, 3); wr(2, 4); wr(3, 8'hA5);
    run(1, 3, 4, 8'hA5, 1'b1, 1'b1);
    run(4, 3, 1, 8'h00, 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule